// File: doc/BRIEF.md
# UART Baud Clock Source Generator

This block makes the bit-timing strobes for one UART channel, one for the transmitter and one for the receiver. It has two possible sources. The first is the bus clock, which goes through a fixed divide-by-32 prescaler and then through a programmable 16-bit divider. The second is an external timer pin. That pin is synchronized into the bus clock domain and its rising edges are used either one-for-one (synchronous, one edge per bit) or divided by 16 (asynchronous, 16x oversampling).

All outputs are single-cycle enables in the bus clock domain. The serial shifters use them together with a per-direction flag that says whether each strobe marks a whole bit or a 16x sample.

A small byte-wide write port sets three things:

- the upper byte of the divisor;
- the lower byte of the divisor;
- a select byte that holds one 4-bit source field per direction.

Top module: `uart_baud_gen`

## Requirements
- R1: While rst_ni is low, tx_tick_o, rx_tick_o, tx_x1_o and rx_x1_o are all 0. Reset leaves the divisor at 0 and both directions on the internal source.
- R2: On the internal source, a strobe occurs every 32 × D bus cycles, where D is the committed divisor.
- R3: Address 0 writes divisor bits 15..8 and address 1 writes bits 7..0. A new divisor is committed on the write that completes the pair, in either order.
- R4: A divisor with only one of its two bytes written has no effect on the strobe period.
- R5: A committed divisor of 0 acts as 1, giving a strobe every 32 bus cycles.
- R6: Select code 4'h2 (external, x1) gives one strobe per rising edge of ext_clk_i and drives that direction's x1 flag to 1. With no pin edges there are no strobes.
- R7: Select code 4'h1 (external, /16) gives one strobe per 16 rising edges of ext_clk_i, with the x1 flag at 0.
- R8: Address 2 bits 3..0 select the transmit source and bits 7..4 select the receive source. The two directions run independently of each other.
- R9: Every strobe is high for exactly one bus cycle.
- R10: Any select code other than 4'h1 or 4'h2 selects the internal source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 divisor high, 1 divisor low, 2 select |
| wr_data_i | input | 8 | Register write data |
| ext_clk_i | input | 1 | External timer clock pin, asynchronous |
| tx_tick_o | output | 1 | Transmit bit-timing enable |
| tx_x1_o | output | 1 | 1 when transmit strobes are whole bits (x1) |
| rx_tick_o | output | 1 | Receive bit-timing enable |
| rx_x1_o | output | 1 | 1 when receive strobes are whole bits (x1) |

## Verification
The bench uses the default parameters: a 32 prescale, an external divide of 16 and a two-stage synchronizer. These keep an internal period with an upper-byte divisor (0x0102, 8256 cycles) and sixteen external edges short enough to measure several times in each run. The external pin toggles every four bus cycles, which sits on the edge of the allowed rate, so x1 and /16 strobes arrive densely next to the internal ones. The skipped first interval after each change of configuration absorbs the free-running prescaler phase, so the exact period can be checked from there on.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    SRC_INT   = 2'd0,
    SRC_EXT16 = 2'd1,
    SRC_EXT1  = 2'd2
  } src_e;

  function automatic src_e decode_sel(input logic [SEL_W-1:0] f);
    case (f)
      4'h1:    return SRC_EXT16;
      4'h2:    return SRC_EXT1;
      default: return SRC_INT;
    endcase
  endfunction
endpackage

// File: rtl/uart_baud_regs.sv
module uart_baud_regs
  import uart_baud_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DIV_W = 2 * BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_addr_i,
  input  logic [BYTE_W-1:0]    wr_data_i,
  output logic [DIV_W-1:0]     div_o,
  output logic                 commit_o,
  output logic [2*SEL_W-1:0]   sel_o
);
  logic [BYTE_W-1:0]  hi_q, lo_q;
  logic               hi_pend_q, lo_pend_q, commit_q;
  logic [DIV_W-1:0]   div_q;
  logic [2*SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q      <= '0;
      lo_q      <= '0;
      hi_pend_q <= 1'b0;
      lo_pend_q <= 1'b0;
      div_q     <= '0;
      commit_q  <= 1'b0;
      sel_q     <= '0;
    end else begin
      commit_q <= 1'b0;
      if (wr_en_i) begin
        case (wr_addr_i)
          2'd0: begin
            if (lo_pend_q) begin
              div_q     <= {wr_data_i, lo_q};
              lo_pend_q <= 1'b0;
              commit_q  <= 1'b1;
            end else begin
              hi_q      <= wr_data_i;
              hi_pend_q <= 1'b1;
            end
          end
          2'd1: begin
            if (hi_pend_q) begin
              div_q     <= {hi_q, wr_data_i};
              hi_pend_q <= 1'b0;
              commit_q  <= 1'b1;
            end else begin
              lo_q      <= wr_data_i;
              lo_pend_q <= 1'b1;
            end
          end
          2'd2:    sel_q <= wr_data_i[2*SEL_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign div_o    = div_q;
  assign commit_o = commit_q;
  assign sel_o    = sel_q;

  // divisor only moves on the write that completes a byte pair
  p_pair_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_q) |-> $past(wr_en_i) && ($past(hi_pend_q) || $past(lo_pend_q)));
endmodule

// File: rtl/uart_baud_prescale.sv
module uart_baud_prescale #(
  parameter int PRE_DIV = 32,
  parameter int DIV_W   = 16,
  localparam int PRE_W  = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             commit_i,
  output logic             tick_o
);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] pre_cnt_q;
  logic [DIV_W-1:0] dcnt_q, div_last;
  logic             pre_tick, tick_q;

  assign pre_tick = (pre_cnt_q == PRE_LAST);
  // zero divisor behaves as one
  assign div_last = (div_i == '0) ? '0 : div_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt_q <= '0;
      dcnt_q    <= '0;
      tick_q    <= 1'b0;
    end else begin
      pre_cnt_q <= pre_tick ? '0 : pre_cnt_q + 1'b1;
      tick_q    <= pre_tick && (dcnt_q == div_last) && !commit_i;
      if (commit_i)      dcnt_q <= '0;
      else if (pre_tick) dcnt_q <= (dcnt_q == div_last) ? '0 : dcnt_q + 1'b1;
    end
  end

  assign tick_o = tick_q;

  p_pre_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(pre_cnt_q) == PRE_LAST);
  p_div_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dcnt_q <= div_last);
endmodule

// File: rtl/uart_baud_ext_sync.sv
module uart_baud_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], pin_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~prev_q;

  p_rise_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/uart_baud_dir.sv
module uart_baud_dir
  import uart_baud_pkg::*;
#(
  parameter int EXT_DIV = 16,
  localparam int E_W    = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             int_tick_i,
  input  logic             ext_rise_i,
  output logic             tick_o,
  output logic             x1_o
);
  localparam logic [E_W-1:0] E_LAST = E_W'(EXT_DIV - 1);

  src_e           src;
  logic [E_W-1:0] e16_cnt_q;
  logic           tick_q, x1_q;

  assign src = decode_sel(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e16_cnt_q <= '0;
      tick_q    <= 1'b0;
      x1_q      <= 1'b0;
    end else begin
      x1_q <= (src == SRC_EXT1);
      if (src != SRC_EXT16)  e16_cnt_q <= '0;
      else if (ext_rise_i)   e16_cnt_q <= (e16_cnt_q == E_LAST) ? '0 : e16_cnt_q + 1'b1;
      case (src)
        SRC_EXT1:  tick_q <= ext_rise_i;
        SRC_EXT16: tick_q <= ext_rise_i && (e16_cnt_q == E_LAST);
        default:   tick_q <= int_tick_i;
      endcase
    end
  end

  assign tick_o = tick_q;
  assign x1_o   = x1_q;

  p_one_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  p_x1_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && x1_o |-> $past(ext_rise_i));
  p_ext16_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && $past(src == SRC_EXT16) |-> $past(ext_rise_i && e16_cnt_q == E_LAST));
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_baud_pkg::*;
#(
  parameter int PRE_DIV     = 32,
  parameter int EXT_DIV     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              ext_clk_i,
  output logic              tx_tick_o,
  output logic              tx_x1_o,
  output logic              rx_tick_o,
  output logic              rx_x1_o
);
  localparam int DIV_W = 2 * BYTE_W;
  localparam int N_DIR = 2;  // 0 transmit, 1 receive

  logic [DIV_W-1:0]       div;
  logic                   commit, int_tick, ext_rise;
  logic [2*SEL_W-1:0]     sel;
  logic [N_DIR-1:0]       tick, x1;

  uart_baud_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .div_o(div), .commit_o(commit), .sel_o(sel)
  );

  uart_baud_prescale #(.PRE_DIV(PRE_DIV), .DIV_W(DIV_W)) u_pre (
    .clk_i, .rst_ni, .div_i(div), .commit_i(commit), .tick_o(int_tick)
  );

  uart_baud_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pin_i(ext_clk_i), .rise_o(ext_rise)
  );

  for (genvar g = 0; g < N_DIR; g++) begin : g_dir
    uart_baud_dir #(.EXT_DIV(EXT_DIV)) u_dir (
      .clk_i, .rst_ni,
      .sel_i(sel[g*SEL_W +: SEL_W]),
      .int_tick_i(int_tick), .ext_rise_i(ext_rise),
      .tick_o(tick[g]), .x1_o(x1[g])
    );
  end

  assign tx_tick_o = tick[0];
  assign tx_x1_o   = x1[0];
  assign rx_tick_o = tick[1];
  assign rx_x1_o   = x1[1];
endmodule

// File: tb/sim_uart_baud_gen.sv
module sim_uart_baud_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ext = 1'b0, ext_run = 1'b0;
  logic       tx_tick, tx_x1, rx_tick, rx_x1;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  int    tx_q[$], rx_q[$];
  string tx_tag[$], rx_tag[$];
  int    tx_last, rx_last, tx_cnt = 0, rx_cnt = 0, width_err = 0;
  bit    tx_have = 0, rx_have = 0, tx_prev = 0, rx_prev = 0;

  uart_baud_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ext_clk_i(ext), .tx_tick_o(tx_tick), .tx_x1_o(tx_x1),
    .rx_tick_o(rx_tick), .rx_x1_o(rx_x1)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // external pin: 8 bus cycles per period
  always begin
    @(posedge clk); #1;
    if (ext_run) begin
      ext = 1'b1; repeat (4) @(posedge clk); #1;
      ext = 1'b0; repeat (3) @(posedge clk);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compares tick intervals against queued expectations (0 = discard)
  always @(negedge clk) if (rst_n) begin
    if (tx_tick && tx_prev) width_err++;
    if (rx_tick && rx_prev) width_err++;
    tx_prev = tx_tick; rx_prev = rx_tick;
    if (tx_tick) begin
      tx_cnt++;
      if (tx_have && tx_q.size() > 0) begin
        int e; string t;
        e = tx_q.pop_front(); t = tx_tag.pop_front();
        if (e != 0) check(cyc - tx_last == e, {t, " tx period"}, cyc - tx_last, e);
      end
      tx_last = cyc; tx_have = 1;
    end
    if (rx_tick) begin
      rx_cnt++;
      if (rx_have && rx_q.size() > 0) begin
        int e; string t;
        e = rx_q.pop_front(); t = rx_tag.pop_front();
        if (e != 0) check(cyc - rx_last == e, {t, " rx period"}, cyc - rx_last, e);
      end
      rx_last = cyc; rx_have = 1;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic expect_tx(input int n, input int p, input string tag);
    tx_q.push_back(0); tx_tag.push_back(tag);
    for (int i = 0; i < n; i++) begin tx_q.push_back(p); tx_tag.push_back(tag); end
  endtask

  task automatic expect_rx(input int n, input int p, input string tag);
    rx_q.push_back(0); rx_tag.push_back(tag);
    for (int i = 0; i < n; i++) begin rx_q.push_back(p); rx_tag.push_back(tag); end
  endtask

  task automatic drain();
    while (tx_q.size() > 0 || rx_q.size() > 0) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    finish_run();
  end

  initial begin
    int t0, r0;
    // R1: outputs quiet in reset
    repeat (5) @(negedge clk);
    check(!tx_tick && !rx_tick, "R1 ticks in reset", tx_tick + rx_tick, 0);
    check(!tx_x1 && !rx_x1, "R1 x1 flags in reset", tx_x1 + rx_x1, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1/R5: reset divisor 0 behaves as 1 on internal source
    expect_tx(3, 32, "R1"); expect_rx(2, 32, "R1");
    drain();

    // R2: divisor 3
    wr(2'd0, 8'h00); wr(2'd1, 8'h03);
    expect_tx(3, 96, "R2"); expect_rx(2, 96, "R2");
    drain();

    // R4: upper byte only, period unchanged
    wr(2'd0, 8'h01);
    expect_tx(2, 96, "R4");
    drain();
    // R3: completing low byte commits 0x0102
    wr(2'd1, 8'h02);
    expect_tx(2, 8256, "R3");
    drain();
    // R3: low-then-high order, 5
    wr(2'd1, 8'h05); wr(2'd0, 8'h00);
    expect_tx(3, 160, "R3");
    drain();
    // R5: explicit zero divisor
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    expect_tx(2, 32, "R5");
    drain();

    // R8/R6: tx internal, rx external x1
    ext_run = 1'b1;
    wr(2'd2, 8'h20);
    @(negedge clk);
    check(rx_x1 == 1'b1, "R6 rx x1 flag", rx_x1, 1);
    check(tx_x1 == 1'b0, "R8 tx x1 flag", tx_x1, 0);
    expect_rx(3, 8, "R6"); expect_tx(2, 32, "R8");
    drain();

    // R7/R8: rx external /16, tx external x1
    wr(2'd2, 8'h12);
    @(negedge clk);
    check(rx_x1 == 1'b0, "R7 rx x1 flag", rx_x1, 0);
    check(tx_x1 == 1'b1, "R8 tx x1 flag", tx_x1, 1);
    expect_rx(2, 128, "R7"); expect_tx(4, 8, "R8");
    drain();

    // R10: unused code selects internal
    wr(2'd2, 8'hFF);
    @(negedge clk);
    check(!tx_x1 && !rx_x1, "R10 x1 flags", tx_x1 + rx_x1, 0);
    expect_tx(2, 32, "R10"); expect_rx(2, 32, "R10");
    drain();

    // R6: x1 mode with pin idle gives no strobes
    ext_run = 1'b0;
    wr(2'd2, 8'h22);
    repeat (20) @(negedge clk);
    t0 = tx_cnt; r0 = rx_cnt;
    repeat (200) @(negedge clk);
    check(tx_cnt == t0 && rx_cnt == r0, "R6 idle pin strobes",
          (tx_cnt - t0) + (rx_cnt - r0), 0);

    // R9: every strobe one cycle wide
    check(width_err == 0, "R9 strobe width", width_err, 0);
    finish_run();
  end
endmodule